// File: doc/BRIEF.md
# One-Time-Programmable Word Memory Control Model

This block is a synthesizable behavioural model of the control logic around a small one-time-programmable word memory. A parameterized array of 16-bit words starts with every bit set. Bits can only be cleared: each program cycle ANDs the supplied data into the addressed word. The block decodes four control inputs into one of eight operating modes. The inputs are an active-low chip enable, an active-low output enable, a flag that marks the program supply as present, and a flag that marks an overvoltage on address line 9. The decoded mode then decides whether the addressed word is written, driven out, replaced by an identifier code, or held back.

Output drivers are modelled by a drive-enable signal, `dout_en`. Whenever `dout_en` is low the data bus reads zero, which stands for high impedance. In identify mode the block returns one of two 16-bit codes, chosen by address bit 0. Each code has a 15-bit payload parameter, and bit 15 is computed in logic to give the code odd parity. Address bits above the array index are not decoded, so higher addresses alias onto the same words. All decode and read paths are combinational. Only the array is clocked.

Top module: `otp_ctrl_model`

## Requirements
- R1: While `rst_n` is low every stored word returns to 16'hFFFF, and no write takes place, whatever the control inputs are.
- R2: With `vpp_on`=0, `ce_n`=0, `oe_n`=0 and `id_hv`=0, the block reports mode 0 (read). It sets `dout_en`=1 and drives the word indexed by `addr[ARR_AW-1:0]`.
- R3: With `vpp_on`=0, the block reports mode 1 (output disabled) when `ce_n`=0 and `oe_n`=1, and mode 2 (standby) when `ce_n`=1. In both modes `dout_en`=0 and `dout`=0.
- R4: With `vpp_on`=1, `ce_n`=0 and `oe_n`=1, the block reports mode 3 (program). At the next clock edge the addressed word becomes its old value ANDed with `din`.
- R5: Programming never sets a bit. A data bit of 1 in a position that already holds 0 leaves that 0 in place.
- R6: With `vpp_on`=1, the block reports mode 4 (inhibit) when `ce_n`=1 and `oe_n`=1, and also when `ce_n`=0 and `oe_n`=0. In mode 4 no word changes and `dout_en`=0.
- R7: With `vpp_on`=1, `ce_n`=1 and `oe_n`=0, the block reports mode 5 (verify). It sets `dout_en`=1 and drives the stored word at the index.
- R8: With `vpp_on`=0, `ce_n`=0, `oe_n`=0, `id_hv`=1, and every address bit except bits 0 and 9 at 0, the block reports mode 6 (identify). It sets `dout_en`=1 and drives the manufacturer code when `addr[0]`=0 and the device code when `addr[0]`=1. The value of `addr[9]` has no effect.
- R9: Each identifier code is {p, payload[14:0]}, where p = ~^payload. The code therefore has an odd number of ones. With the default payloads the codes are 16'h1234 (manufacturer) and 16'hAA5B (device).
- R10: Under the R8 conditions with any address bit other than 0 and 9 set, the block reports mode 7 (identify error). It sets `id_err`=1, `dout_en`=0 and `dout`=0. In every other mode `id_err`=0.
- R11: `id_hv` is ignored while `vpp_on`=1. Program, inhibit and verify behave as in R4, R6 and R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for array updates |
| rst_n | input | 1 | Asynchronous active-low reset, sets every word to all ones |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_on | input | 1 | Program supply present |
| id_hv | input | 1 | Overvoltage present on address line 9 |
| addr | input | ADDR_W (10) | Word address |
| din | input | DATA_W (16) | Data to program |
| dout | output | DATA_W (16) | Output data, zero when not driven |
| dout_en | output | 1 | Output drivers enabled |
| id_err | output | 1 | Identify requested with a bad address |
| mode | output | 3 | Decoded mode, 0 to 7 as in R2 to R10 |

## Verification
The assertions assume that the control inputs, address and data are synchronous to `clk`, stable around its rising edge and never unknown. The array checks rely on this when they compare a word before and after an edge. The bench changes every input on the falling edge to defined values only. It compares outputs half a cycle later, before the array can update. The same discipline holds during reset, so the write-suppression checks see a clean edge.

// File: rtl/otp_pkg.sv
package otp_pkg;

   typedef enum logic [2:0] {
      M_READ    = 3'd0,
      M_OUTDIS  = 3'd1,
      M_STANDBY = 3'd2,
      M_PROGRAM = 3'd3,
      M_INHIBIT = 3'd4,
      M_VERIFY  = 3'd5,
      M_IDENT   = 3'd6,
      M_IDERR   = 3'd7
   } otp_mode_e;

   // modes in which the output drivers are on
   function automatic logic mode_drives(otp_mode_e m);
      return (m == M_READ) || (m == M_VERIFY) || (m == M_IDENT);
   endfunction

endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
   import otp_pkg::*;
#(
   parameter int ADDR_W   = 10,
   parameter int ID_BIT   = 9,
   parameter int SEL_BIT  = 0
) (
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              vpp_on,
   input  logic              id_hv,
   input  logic [ADDR_W-1:0] addr,
   output otp_mode_e         mode,
   output logic              wr_req
);

   localparam logic [ADDR_W-1:0] IGNORE_MASK =
      (ADDR_W'(1) << ID_BIT) | (ADDR_W'(1) << SEL_BIT);

   logic addr_clean;

   initial begin
      assert (ID_BIT < ADDR_W && SEL_BIT < ADDR_W && ID_BIT != SEL_BIT)
         else $fatal(1, "otp_mode_dec: bad identify bit positions");
   end

   assign addr_clean = ((addr & ~IGNORE_MASK) == '0);

   always_comb begin
      mode = M_STANDBY;
      if (vpp_on) begin
         unique case ({ce_n, oe_n})
            2'b01:   mode = M_PROGRAM;
            2'b10:   mode = M_VERIFY;
            default: mode = M_INHIBIT;
         endcase
      end else if (ce_n) begin
         mode = M_STANDBY;
      end else if (oe_n) begin
         mode = M_OUTDIS;
      end else if (id_hv) begin
         mode = addr_clean ? M_IDENT : M_IDERR;
      end else begin
         mode = M_READ;
      end
   end

   assign wr_req = (mode == M_PROGRAM);

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 16,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DEPTH-1:0][DATA_W-1:0] cells;

   initial begin
      assert (DEPTH >= 2 && (1 << AW) == DEPTH)
         else $fatal(1, "otp_cell_array: DEPTH must be a power of two");
   end

   // one register row per word; a row clears bits only when selected
   for (genvar w = 0; w < DEPTH; w++) begin : g_row
      logic row_hit;
      assign row_hit = wr_en && (idx == AW'(w));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cells[w] <= '1;
         else if (row_hit)
            cells[w] <= cells[w] & wdata;
      end
   end

   assign rdata = cells[idx];

   AST_PROG_AND: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (cells[$past(idx)] == ($past(rdata) & $past(wdata)))); // R4

   AST_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((cells[$past(idx)] & ~$past(rdata)) == '0)); // R5

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cells)); // R6

endmodule

// File: rtl/otp_id_rom.sv
module otp_id_rom #(
   parameter int          DATA_W      = 16,
   parameter logic [14:0] MFR_PAYLOAD = 15'h1234,
   parameter logic [14:0] DEV_PAYLOAD = 15'h2A5B,
   parameter bit          ODD_PARITY  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_dev,
   output logic [DATA_W-1:0] code
);

   logic [14:0] payload;
   logic        par_bit;

   initial begin
      assert (DATA_W == 16)
         else $fatal(1, "otp_id_rom: identifier codes are 16 bits");
   end

   assign payload = sel_dev ? DEV_PAYLOAD : MFR_PAYLOAD;

   if (ODD_PARITY) begin : g_odd
      assign par_bit = ~^payload;
   end else begin : g_even
      assign par_bit = ^payload;
   end

   assign code = {par_bit, payload};

   AST_ID_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      (^code) == ODD_PARITY); // R9

endmodule

// File: rtl/otp_out_mux.sv
module otp_out_mux
   import otp_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  otp_mode_e         mode,
   input  logic [DATA_W-1:0] word,
   input  logic [DATA_W-1:0] id_code,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic              id_err
);

   always_comb begin
      dout = '0;
      unique case (mode)
         M_READ, M_VERIFY: dout = word;
         M_IDENT:          dout = id_code;
         default:          dout = '0;
      endcase
   end

   assign dout_en = mode_drives(mode);
   assign id_err  = (mode == M_IDERR);

   AST_ERR_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      id_err |-> (!dout_en && dout == '0)); // R10

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_en |-> (dout == '0)); // R3

endmodule

// File: rtl/otp_ctrl_model.sv
module otp_ctrl_model
   import otp_pkg::*;
#(
   parameter int          ADDR_W      = 10,
   parameter int          DEPTH       = 64,
   parameter int          DATA_W      = 16,
   parameter logic [14:0] MFR_PAYLOAD = 15'h1234,
   parameter logic [14:0] DEV_PAYLOAD = 15'h2A5B,
   localparam int         ARR_AW      = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              vpp_on,
   input  logic              id_hv,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic              id_err,
   output logic [2:0]        mode
);

   otp_mode_e         mode_q;
   logic              wr_req;
   logic              wr_en;
   logic [DATA_W-1:0] word;
   logic [DATA_W-1:0] id_code;

   initial begin
      assert (ADDR_W >= 10 && ARR_AW <= ADDR_W)
         else $fatal(1, "otp_ctrl_model: address too narrow");
   end

   otp_mode_dec #(.ADDR_W(ADDR_W), .ID_BIT(9), .SEL_BIT(0)) i_dec (
      .ce_n   (ce_n),
      .oe_n   (oe_n),
      .vpp_on (vpp_on),
      .id_hv  (id_hv),
      .addr   (addr),
      .mode   (mode_q),
      .wr_req (wr_req)
   );

   assign wr_en = wr_req && rst_n;

   otp_cell_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_arr (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .idx   (addr[ARR_AW-1:0]),
      .wdata (din),
      .rdata (word)
   );

   otp_id_rom #(
      .DATA_W(DATA_W), .MFR_PAYLOAD(MFR_PAYLOAD),
      .DEV_PAYLOAD(DEV_PAYLOAD), .ODD_PARITY(1'b1)
   ) i_id (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_dev (addr[0]),
      .code    (id_code)
   );

   otp_out_mux #(.DATA_W(DATA_W)) i_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode_q),
      .word    (word),
      .id_code (id_code),
      .dout    (dout),
      .dout_en (dout_en),
      .id_err  (id_err)
   );

   assign mode = mode_q;

   AST_DRIVE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      dout_en |-> (!oe_n && (vpp_on ? ce_n : !ce_n))); // R2

   AST_HV_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      vpp_on |-> !id_err); // R11

endmodule

// File: tb/test_otp_ctrl_model.sv
module test_otp_ctrl_model;

   localparam int AW = 10;
   localparam int DEPTH = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, vpp_on = 1'b0, id_hv = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [15:0]   din = '0;
   logic [15:0]   dout;
   logic          dout_en, id_err;
   logic [2:0]    mode;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   int model_mem [DEPTH];

   always #2 clk = ~clk;

   otp_ctrl_model i_otp_ctrl_model (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_on(vpp_on),
      .id_hv(id_hv), .addr(addr), .din(din), .dout(dout),
      .dout_en(dout_en), .id_err(id_err), .mode(mode)
   );

   function automatic int id_code(int payload);
      int ones = 0;
      for (int b = 0; b < 15; b++) ones += (payload >> b) & 1;
      return (ones % 2 == 0) ? (payload | 32'h8000) : payload;
   endfunction

   function automatic int exp_mode();
      bit clean = ((addr & ~10'h201) == 0);
      if (vpp_on) begin
         if (!ce_n && oe_n) return 3;
         if (ce_n && !oe_n) return 5;
         return 4;
      end
      if (ce_n) return 2;
      if (oe_n) return 1;
      if (id_hv) return clean ? 6 : 7;
      return 0;
   endfunction

   function automatic string req_of(int m);
      case (m)
         0: return "R2 read";
         1, 2: return "R3 idle";
         3: return "R4 program";
         4: return "R6 inhibit";
         5: return "R7 verify";
         6: return "R8/R9 identify";
         default: return "R10 id error";
      endcase
   endfunction

   // drive one cycle on the falling edge, compare before the rising edge
   task automatic cyc(input logic r, input logic c, input logic o,
                      input logic v, input logic h, input int a, input int d);
      int m, e_data, e_en, e_err, idx;
      @(negedge clk);
      rst_n = r; ce_n = c; oe_n = o; vpp_on = v; id_hv = h;
      addr = AW'(a); din = 16'(d);
      if (!r) for (int k = 0; k < DEPTH; k++) model_mem[k] = 16'hFFFF; // R1
      #1;
      m = exp_mode();
      idx = a % DEPTH;
      e_en = (m == 0 || m == 5 || m == 6);
      e_err = (m == 7);
      e_data = (m == 0 || m == 5) ? model_mem[idx] :
               (m == 6) ? id_code((a & 1) ? 15'h2A5B : 15'h1234) : 0;
      total++;
      if (mode != 3'(m) || dout_en != e_en[0] || id_err != e_err[0] ||
          dout != 16'(e_data)) begin
         bad++;
         $display("FAIL %s: got mode=%0d en=%0d err=%0d dout=%h, want mode=%0d en=%0d err=%0d dout=%h",
                  req_of(m), mode, dout_en, id_err, dout, m, e_en, e_err, e_data[15:0]);
      end
      // R4 R5 model update at the coming edge; R1 no write in reset
      if (r && m == 3) model_mem[idx] = model_mem[idx] & d;
   endtask

   initial begin
      int s = 32'h1ACE;
      for (int k = 0; k < DEPTH; k++) model_mem[k] = 16'hFFFF;
      // R1: program attempts during reset are suppressed
      cyc(0, 0, 1, 1, 0, 1, 16'h0000);
      cyc(0, 0, 1, 1, 0, 1, 16'h0000);
      cyc(0, 1, 1, 0, 0, 0, 0);
      cyc(1, 0, 0, 0, 0, 1, 0);          // R1 word 1 still ones
      cyc(1, 0, 0, 0, 0, 63, 0);         // R2
      // R4: program and verify
      cyc(1, 0, 1, 1, 0, 3, 16'hA5F0);
      cyc(1, 1, 0, 1, 0, 3, 0);          // R7
      cyc(1, 0, 1, 1, 0, 3, 16'h0FFF);   // R5: AND gives 05F0
      cyc(1, 1, 0, 1, 0, 3, 0);
      cyc(1, 0, 1, 1, 0, 3, 16'hFFFF);   // R5: ones do not set
      cyc(1, 0, 0, 0, 0, 3, 0);          // R2
      cyc(1, 0, 0, 0, 0, 3 + 64, 0);     // R2 alias
      // R6: inhibit both ways, word unchanged
      cyc(1, 1, 1, 1, 0, 3, 0);
      cyc(1, 0, 0, 1, 0, 3, 0);
      cyc(1, 1, 0, 1, 0, 3, 0);
      // R3
      cyc(1, 0, 1, 0, 0, 3, 0);
      cyc(1, 1, 0, 0, 0, 3, 0);
      // R8 R9: identify, bit 9 either value
      cyc(1, 0, 0, 0, 1, 0, 0);
      cyc(1, 0, 0, 0, 1, 1, 0);
      cyc(1, 0, 0, 0, 1, 10'h200, 0);
      cyc(1, 0, 0, 0, 1, 10'h201, 0);
      // R10: stray address bits
      cyc(1, 0, 0, 0, 1, 10'h020, 0);
      cyc(1, 0, 0, 0, 1, 10'h203, 0);
      // R11: id_hv ignored with program supply
      cyc(1, 0, 1, 1, 1, 10'h205, 16'h00FF);
      cyc(1, 1, 0, 1, 1, 10'h205, 0);
      // R1: second reset restores ones
      cyc(0, 1, 1, 0, 0, 3, 0);
      cyc(1, 0, 0, 0, 0, 3, 0);
      // mixed stimulus
      for (int i = 0; i < 3000; i++) begin
         int a;
         s = s * 1103515245 + 12345;
         a = (s >>> 8) & ((s[3]) ? 32'h201 : 32'h3FF);
         cyc((s[31:28] != 0), s[20], s[21], s[22] & s[23], s[24], a,
             (s >>> 5) & 16'hFFFF);
      end
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: got hang, want finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule